// File: doc/BRIEF.md
# Interrupt Response Sequencer

This block is the interrupt front end of a small 8-bit processor core. It watches two request lines: a non-maskable line that acts on its rising edge and a maskable line that is caught in a sticky latch. At each instruction-boundary strobe from the core it decides whether to take an interrupt. It keeps the primary and shadow enable flags. For a maskable request it drives the acknowledge bus cycle, with its active-low strobes and added wait states. Each accepted interrupt ends with a one-cycle call request that carries the target address to the core.

The core reports decoded events as single-cycle strobes: enable, disable, mode select with a two-bit value, and return-from-non-maskable. It also supplies the page register byte and the data bus. The core stalls while `busy_o` is high. Boundary strobes that arrive during that time are ignored.

Top module: `int_resp_seq`

## Requirements
- R1: A rising edge on `nmi_i` is serviced at the next boundary strobe. `call_valid_o` pulses one cycle after that boundary with `call_addr_o` = 0x0066. One pulse gives exactly one service.
- R2: Accepting a non-maskable request copies the primary enable flag into the shadow flag and clears the primary flag. Maskable requests are then refused.
- R3: A return-from-non-maskable strobe copies the shadow flag back into the primary flag. Maskable service resumes only if it was enabled before the non-maskable entry.
- R4: A one-cycle pulse on `int_i` is held until a boundary accepts it. The latch clears on acceptance, so a single pulse gives a single service.
- R5: In the cycle after a maskable acceptance, `m1_n_o` is low alone. In the next three cycles, `m1_n_o` and `iorq_n_o` are both low: two wait cycles, then one read cycle that samples `data_i`. In the cycle after that, `call_valid_o` pulses and both strobes are high. `iorq_n_o` is never low while `m1_n_o` is high.
- R6: In mode 0 the target is {8'h00, 2'b00, data[5:3], 3'b000}: one of eight restart addresses.
- R7: In mode 1 the target is 0x0038, whatever the bus byte.
- R8: In mode 2 the target is {page_i, data[7:1], 1'b0}.
- R9: A mode-select strobe loads `im_val_i` values 0, 1 or 2. Value 3 leaves the mode unchanged. Reset selects mode 0.
- R10: When both kinds are pending at one boundary, the non-maskable request wins. The maskable request stays latched.
- R11: After reset or a disable strobe, maskable requests are not serviced and `busy_o` stays low.
- R12: After an enable strobe, the first boundary still refuses maskable requests. The boundary after it can accept one.
- R13: Accepting a maskable request clears both enable flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| boundary_i | input | 1 | Instruction-boundary strobe |
| ei_i | input | 1 | Enable-interrupts event |
| di_i | input | 1 | Disable-interrupts event |
| im_set_i | input | 1 | Mode-select event |
| im_val_i | input | 2 | Mode value for mode select |
| retn_i | input | 1 | Return-from-non-maskable event |
| nmi_i | input | 1 | Non-maskable request, rising-edge sensitive |
| int_i | input | 1 | Maskable request, active high, latched |
| page_i | input | 8 | Page register, high byte of the mode-2 pointer |
| data_i | input | 8 | Data bus byte during acknowledge |
| m1_n_o | output | 1 | Active-low fetch strobe |
| iorq_n_o | output | 1 | Active-low I/O request strobe |
| busy_o | output | 1 | Sequence in progress; the core stalls |
| call_valid_o | output | 1 | One-cycle call request |
| call_addr_o | output | 16 | Call target, zero when no call is requested |

## Verification
The hardest case to reach is the shadow-flag path. A maskable request must be latched and left waiting while a non-maskable entry takes priority, and must stay blocked until the return strobe restores the primary flag. The stimulus enables interrupts and lets one boundary pass to clear the post-enable block. It then raises both requests before a single boundary, checks that only the 0x0066 call appears and that a following boundary stays quiet, and issues the return strobe so that the still-latched maskable request is served. A second run starts with interrupts disabled and shows that the same return strobe keeps maskable service off.

// File: rtl/irs_pkg.sv
package irs_pkg;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;
    localparam logic [ADDR_W-1:0] NMI_TARGET   = 16'h0066;
    localparam logic [ADDR_W-1:0] FIXED_TARGET = 16'h0038;

    typedef enum logic [1:0] {
        IM_RESTART = 2'd0,
        IM_FIXED   = 2'd1,
        IM_TABLE   = 2'd2
    } imode_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_NMI,
        S_ACK,
        S_WAIT,
        S_READ,
        S_CALL
    } seq_st_t;

    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] addr;
    } call_t;

    function automatic logic [ADDR_W-1:0] mask_target(
        input imode_t            m,
        input logic [DATA_W-1:0] page,
        input logic [DATA_W-1:0] bus
    );
        case (m)
            IM_RESTART: return {8'h00, 2'b00, bus[5:3], 3'b000};
            IM_FIXED:   return FIXED_TARGET;
            default:    return {page, bus[7:1], 1'b0};
        endcase
    endfunction
endpackage

// File: rtl/irs_req_capture.sv
module irs_req_capture (
    input  logic clk,
    input  logic rst,
    input  logic nmi_i,
    input  logic int_i,
    input  logic take_nmi,
    input  logic take_irq,
    output logic nmi_pend,
    output logic irq_pend
);
    logic nmi_q;
    logic nmi_rise;

    assign nmi_rise = nmi_i & ~nmi_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            nmi_q    <= 1'b0;
            nmi_pend <= 1'b0;
            irq_pend <= 1'b0;
        end else begin
            nmi_q    <= nmi_i;
            // a new edge arriving while the old one is taken is kept
            nmi_pend <= (nmi_pend & ~take_nmi) | nmi_rise;
            if (take_irq)
                irq_pend <= 1'b0;
            else
                irq_pend <= irq_pend | int_i;
        end
    end
endmodule

// File: rtl/irs_enable_flags.sv
module irs_enable_flags (
    input  logic clk,
    input  logic rst,
    input  logic boundary,
    input  logic ei,
    input  logic di,
    input  logic retn,
    input  logic take_nmi,
    input  logic take_irq,
    output logic iff1,
    output logic iff2,
    output logic ei_block
);
    always_ff @(posedge clk) begin
        if (rst) begin
            iff1     <= 1'b0;
            iff2     <= 1'b0;
            ei_block <= 1'b0;
        end else begin
            if (take_nmi) begin
                iff2 <= iff1;
                iff1 <= 1'b0;
            end else if (take_irq || di) begin
                iff1 <= 1'b0;
                iff2 <= 1'b0;
            end else if (ei) begin
                iff1 <= 1'b1;
                iff2 <= 1'b1;
            end else if (retn) begin
                iff1 <= iff2;
            end

            if (ei)
                ei_block <= 1'b1;
            else if (boundary)
                ei_block <= 1'b0;
        end
    end
endmodule

// File: rtl/irs_ack_fsm.sv
module irs_ack_fsm
    import irs_pkg::*;
#(
    parameter int ACK_WAITS = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              boundary,
    input  logic              nmi_pend,
    input  logic              irq_pend,
    input  logic              irq_allowed,
    input  imode_t            mode,
    input  logic [DATA_W-1:0] page,
    input  logic [DATA_W-1:0] data,
    output logic              take_nmi,
    output logic              take_irq,
    output logic              m1_n,
    output logic              iorq_n,
    output logic              busy,
    output call_t             call
);
    localparam int CW = $clog2(ACK_WAITS + 1);
    localparam logic [CW-1:0] LAST_WAIT = CW'(ACK_WAITS - 1);

    seq_st_t           st;
    logic [CW-1:0]     wcnt;
    logic [DATA_W-1:0] bus_q;
    logic              idle;

    assign idle     = (st == S_IDLE);
    assign take_nmi = idle & boundary & nmi_pend;
    assign take_irq = idle & boundary & ~nmi_pend & irq_pend & irq_allowed;

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= S_IDLE;
            wcnt  <= '0;
            bus_q <= '0;
        end else begin
            case (st)
                S_IDLE: begin
                    if (take_nmi)
                        st <= S_NMI;
                    else if (take_irq)
                        st <= S_ACK;
                end
                S_NMI: st <= S_IDLE;
                S_ACK: begin
                    wcnt <= '0;
                    st   <= S_WAIT;
                end
                S_WAIT: begin
                    wcnt <= wcnt + 1'b1;
                    if (wcnt == LAST_WAIT)
                        st <= S_READ;
                end
                S_READ: begin
                    bus_q <= data;
                    st    <= S_CALL;
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    always_comb begin
        m1_n       = ~(st == S_ACK || st == S_WAIT || st == S_READ);
        iorq_n     = ~(st == S_WAIT || st == S_READ);
        busy       = ~idle;
        call.valid = (st == S_NMI) || (st == S_CALL);
        if (st == S_NMI)
            call.addr = NMI_TARGET;
        else if (st == S_CALL)
            call.addr = mask_target(mode, page, bus_q);
        else
            call.addr = '0;
    end
endmodule

// File: rtl/int_resp_seq.sv
module int_resp_seq
    import irs_pkg::*;
#(
    parameter int ACK_WAITS = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              boundary_i,
    input  logic              ei_i,
    input  logic              di_i,
    input  logic              im_set_i,
    input  logic [1:0]        im_val_i,
    input  logic              retn_i,
    input  logic              nmi_i,
    input  logic              int_i,
    input  logic [DATA_W-1:0] page_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              m1_n_o,
    output logic              iorq_n_o,
    output logic              busy_o,
    output logic              call_valid_o,
    output logic [ADDR_W-1:0] call_addr_o
);
    logic   take_nmi, take_irq;
    logic   nmi_pend, irq_pend;
    logic   iff1, iff2, ei_block;
    imode_t imode_q;
    call_t  call;

    always_ff @(posedge clk) begin
        if (rst)
            imode_q <= IM_RESTART;
        else if (im_set_i && im_val_i != 2'd3)
            imode_q <= imode_t'(im_val_i);
    end

    irs_req_capture u_req (
        .clk      (clk),
        .rst      (rst),
        .nmi_i    (nmi_i),
        .int_i    (int_i),
        .take_nmi (take_nmi),
        .take_irq (take_irq),
        .nmi_pend (nmi_pend),
        .irq_pend (irq_pend)
    );

    irs_enable_flags u_flags (
        .clk      (clk),
        .rst      (rst),
        .boundary (boundary_i),
        .ei       (ei_i),
        .di       (di_i),
        .retn     (retn_i),
        .take_nmi (take_nmi),
        .take_irq (take_irq),
        .iff1     (iff1),
        .iff2     (iff2),
        .ei_block (ei_block)
    );

    irs_ack_fsm #(.ACK_WAITS(ACK_WAITS)) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .boundary    (boundary_i),
        .nmi_pend    (nmi_pend),
        .irq_pend    (irq_pend),
        .irq_allowed (iff1 & ~ei_block),
        .mode        (imode_q),
        .page        (page_i),
        .data        (data_i),
        .take_nmi    (take_nmi),
        .take_irq    (take_irq),
        .m1_n        (m1_n_o),
        .iorq_n      (iorq_n_o),
        .busy        (busy_o),
        .call        (call)
    );

    assign call_valid_o = call.valid;
    assign call_addr_o  = call.addr;
endmodule

// File: rtl/irs_chk.sv
module irs_chk (
    input logic        clk,
    input logic        rst,
    input logic        retn_i,
    input logic        ei_i,
    input logic        di_i,
    input logic        m1_n_o,
    input logic        iorq_n_o,
    input logic        call_valid_o,
    input logic [15:0] call_addr_o,
    input logic        take_nmi,
    input logic        take_irq,
    input logic        nmi_pend,
    input logic        iff1,
    input logic        iff2
);
    // R1: non-maskable entry yields the fixed call next cycle
    p_nmi_call_r1: assert property (@(posedge clk) disable iff (rst)
        take_nmi |=> (call_valid_o && call_addr_o == 16'h0066));

    // R2: entry saves primary flag into shadow and clears primary
    p_nmi_save_r2: assert property (@(posedge clk) disable iff (rst)
        take_nmi |=> (!iff1 && iff2 == $past(iff1)));

    // R3: return strobe restores primary from shadow
    p_retn_restore_r3: assert property (@(posedge clk) disable iff (rst)
        (retn_i && !take_nmi && !take_irq && !di_i && !ei_i) |=> (iff1 == $past(iff2)));

    // R5: I/O strobe only together with fetch strobe
    p_strobe_pair_r5: assert property (@(posedge clk) disable iff (rst)
        !iorq_n_o |-> !m1_n_o);

    // R5: the joint strobe lasts beyond its first cycle (wait states)
    p_wait_hold_r5: assert property (@(posedge clk) disable iff (rst)
        $fell(iorq_n_o) |=> !iorq_n_o);

    // R10: maskable acceptance never overrides a pending non-maskable
    p_nmi_prio_r10: assert property (@(posedge clk) disable iff (rst)
        take_irq |-> !nmi_pend);

    // R11: maskable acceptance only with primary flag set
    p_mask_gate_r11: assert property (@(posedge clk) disable iff (rst)
        take_irq |-> iff1);

    // R13: maskable acceptance clears both flags
    p_irq_clear_r13: assert property (@(posedge clk) disable iff (rst)
        take_irq |=> (!iff1 && !iff2));

    p_one_take_r10: assert property (@(posedge clk) disable iff (rst)
        $onehot0({take_nmi, take_irq}));
endmodule

bind int_resp_seq irs_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .retn_i       (retn_i),
    .ei_i         (ei_i),
    .di_i         (di_i),
    .m1_n_o       (m1_n_o),
    .iorq_n_o     (iorq_n_o),
    .call_valid_o (call_valid_o),
    .call_addr_o  (call_addr_o),
    .take_nmi     (take_nmi),
    .take_irq     (take_irq),
    .nmi_pend     (nmi_pend),
    .iff1         (iff1),
    .iff2         (iff2)
);

// File: tb/sim_int_resp_seq.sv
module sim_int_resp_seq;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        boundary_i = 0, ei_i = 0, di_i = 0, im_set_i = 0, retn_i = 0;
    logic [1:0]  im_val_i = 0;
    logic        nmi_i = 0, int_i = 0;
    logic [7:0]  page_i = 0, data_i = 0;
    logic        m1_n_o, iorq_n_o, busy_o, call_valid_o;
    logic [15:0] call_addr_o;

    int total = 0;
    int bad   = 0;
    logic [15:0] exp_q[$];
    string       tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    int_resp_seq u0 (
        .clk(clk), .rst(rst), .boundary_i(boundary_i), .ei_i(ei_i), .di_i(di_i),
        .im_set_i(im_set_i), .im_val_i(im_val_i), .retn_i(retn_i), .nmi_i(nmi_i),
        .int_i(int_i), .page_i(page_i), .data_i(data_i), .m1_n_o(m1_n_o),
        .iorq_n_o(iorq_n_o), .busy_o(busy_o), .call_valid_o(call_valid_o),
        .call_addr_o(call_addr_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic boundary();
        boundary_i = 1; tick(); boundary_i = 0;
    endtask

    task automatic ev_ei();   ei_i = 1;   tick(); ei_i = 0;   endtask
    task automatic ev_di();   di_i = 1;   tick(); di_i = 0;   endtask
    task automatic ev_retn(); retn_i = 1; tick(); retn_i = 0; endtask
    task automatic ev_int();  int_i = 1;  tick(); int_i = 0; tick(); endtask
    task automatic ev_nmi();  nmi_i = 1;  tick(2); nmi_i = 0; tick(); endtask
    task automatic ev_mode(input logic [1:0] v);
        im_val_i = v; im_set_i = 1; tick(); im_set_i = 0;
    endtask

    task automatic expect_call(input logic [15:0] a, input string req);
        exp_q.push_back(a);
        tag_q.push_back(req);
    endtask

    function automatic logic [15:0] tgt(input int m, input logic [7:0] pg, input logic [7:0] d);
        if (m == 0) return {8'h00, 2'b00, d[5:3], 3'b000};
        if (m == 1) return 16'h0038;
        return {pg, d[7:1], 1'b0};
    endfunction

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst && call_valid_o) begin
            if (exp_q.size() == 0) begin
                total++; bad++;
                $display("FAIL unexpected call (R11/R12/R13): actual=%0h expected=none", call_addr_o);
            end else begin
                automatic logic [15:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                chk(t, {16'h0, call_addr_o}, {16'h0, e});
            end
        end
    end

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=running expected=done");
        finish_run();
    end

    initial begin
        tick(3); rst = 0; tick();
        // reset state
        chk("R5 reset m1", m1_n_o, 1);
        chk("R5 reset iorq", iorq_n_o, 1);
        chk("R11 reset busy", busy_o, 0);
        chk("R11 reset call", call_valid_o, 0);

        // R11: maskable request with flags clear -> not serviced (stays latched, R4)
        ev_int(); boundary(); tick();
        chk("R11 no service while disabled", busy_o, 0);

        // R12: first boundary after enable refuses
        ev_ei(); boundary();
        chk("R12 first boundary after enable", busy_o, 0);
        data_i = 8'hDF;
        expect_call(tgt(0, page_i, 8'hDF), "R6 mode0 restart");
        boundary();
        // R5 strobe sequence
        chk("R5 ack m1", m1_n_o, 0);  chk("R5 ack iorq", iorq_n_o, 1);
        tick(); chk("R5 wait1 m1", m1_n_o, 0); chk("R5 wait1 iorq", iorq_n_o, 0);
        tick(); chk("R5 wait2 iorq", iorq_n_o, 0);
        tick(); chk("R5 read iorq", iorq_n_o, 0); chk("R5 read m1", m1_n_o, 0);
        tick(); chk("R5 call valid", call_valid_o, 1); chk("R5 call iorq", iorq_n_o, 1);
        tick(); chk("R5 idle busy", busy_o, 0);

        // R13: flags cleared by acceptance
        ev_int(); boundary(); boundary(); tick();
        chk("R13 flags cleared after take", busy_o, 0);

        // R4: latch cleared after single service
        ev_ei(); boundary(); data_i = 8'h00;
        expect_call(tgt(0, page_i, 8'h00), "R4 latched pulse served");
        boundary(); tick(6);
        ev_ei(); boundary(); boundary(); tick();
        chk("R4 latch cleared", busy_o, 0);

        // R7 and R9
        ev_mode(2'd1); data_i = 8'hFF;
        ev_int();
        expect_call(16'h0038, "R7 mode1 fixed");
        boundary(); tick(6);
        ev_mode(2'd3); ev_ei(); boundary(); ev_int(); data_i = 8'h12;
        expect_call(16'h0038, "R9 value 3 ignored");
        boundary(); tick(6);

        // R8
        ev_mode(2'd2); page_i = 8'h3C; data_i = 8'hA7;
        ev_ei(); boundary(); ev_int();
        expect_call(tgt(2, 8'h3C, 8'hA7), "R8 mode2 table");
        boundary(); tick(6);

        // R1: one pulse, one service (flags clear here)
        ev_nmi();
        expect_call(16'h0066, "R1 nmi vector");
        boundary(); tick(2);
        boundary(); tick();
        chk("R1 single service", busy_o, 0);

        // R10 / R2 / R3 with interrupts enabled
        ev_ei(); boundary(); data_i = 8'h5B;
        int_i = 1; nmi_i = 1; tick(); int_i = 0; tick(); nmi_i = 0; tick();
        expect_call(16'h0066, "R10 nmi wins");
        boundary(); tick(2);
        boundary(); tick();
        chk("R2 maskable refused in nmi routine", busy_o, 0);
        ev_retn();
        expect_call(tgt(2, 8'h3C, 8'h5B), "R3 restored enable serves pending");
        boundary(); tick(6);

        // R3 with disabled state before entry
        ev_nmi();
        expect_call(16'h0066, "R1 nmi second");
        boundary(); tick(2);
        ev_retn(); ev_int(); boundary(); tick();
        chk("R3 restored disabled", busy_o, 0);

        // R11 disable strobe
        ev_ei(); ev_di(); boundary(); boundary(); tick();
        chk("R11 disable strobe", busy_o, 0);

        tick(4);
        chk("R1 all expected calls seen", exp_q.size(), 0);
        finish_run();
    end
endmodule